// File: doc/BRIEF.md
# On/Off-Time Pulse Width Generator

This block produces a pulse train whose high interval and low interval are set independently. Each interval is a 16-bit count of microseconds, presented to the block as two byte-wide halves. A divider derived from the clock-frequency parameter provides the microsecond timebase, so the same code serves any clock that is a whole multiple of 1 MHz.

The generator is started by a one-cycle set request and stopped by a one-cycle clear request. The run bit it keeps is visible on `run_q`. Every period opens with the high interval and closes with the low interval. The interval values are captured at the start of each period, so a change made mid-period never cuts a pulse short. In continuous mode, periods follow one another without a gap. In one-shot mode, the generator completes one period and then clears its own run bit.

Top module: `pwm_onoff_gen`

## Requirements
- R1: After reset, `pwm_out` is 0 and `run_q` is 0.
- R2: The high-interval count is {`on_hi`,`on_lo`} and the low-interval count is {`off_hi`,`off_lo`}, with the high byte carrying bits 15:8. One count lasts CLK_HZ/1e6 clock cycles. A period drives `pwm_out` high for the high-interval count and then low for the low-interval count.
- R3: With both counts equal to 1, the output is a square wave with a 2 µs period and 50% duty.
- R4: With `one_shot` at 0, periods repeat back to back with no idle cycle between them.
- R5: With `one_shot` at 1 when a period ends, `run_q` drops to 0 on the clock edge that ends the period, and `pwm_out` stays low from then on.
- R6: On the edge where `run_set` is seen with `run_q` at 0, `run_q` goes to 1 and a fresh period begins. While the generator is already running, `run_set` has no effect.
- R7: On the edge where `run_clr` is seen, `run_q` and `pwm_out` go to 0 and the interval timing is cleared. `run_clr` takes priority over `run_set`, and a later start begins with a full high interval.
- R8: Interval values are captured only when a period starts, so a change takes effect from the next period onward.
- R9: A high-interval count of 0 keeps `pwm_out` low. When both counts are 0, a period lasts one count.
- R10: A low-interval count of 0 with a nonzero high-interval count keeps `pwm_out` high continuously in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_lo | input | 8 | High-interval count, bits 7:0 |
| on_hi | input | 8 | High-interval count, bits 15:8 |
| off_lo | input | 8 | Low-interval count, bits 7:0 |
| off_hi | input | 8 | Low-interval count, bits 15:8 |
| one_shot | input | 1 | 1 = stop after the current period, 0 = continuous |
| run_set | input | 1 | One-cycle request to start the generator |
| run_clr | input | 1 | One-cycle request to stop the generator |
| run_q | output | 1 | Current run bit |
| pwm_out | output | 1 | Pulse output |

## Verification
The assertions assume that `run_set`, `run_clr`, `one_shot` and the four count bytes are synchronous to `clk` and hold known values from reset onward. They also assume that a start or clear request lasts one cycle. The stimulus meets these assumptions by driving every input on the falling edge and releasing each request after exactly one cycle. Count bytes are sometimes changed while a period is running. This is deliberate: it exercises the rule that values are captured only at period start. The stimulus never relies on a mid-period change showing up early.

// File: rtl/pwm_onoff_pkg.sv
package pwm_onoff_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef logic [CNT_W-1:0]  dur_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {PH_OFF = 1'b0, PH_ON = 1'b1} phase_e;

  // clock cycles making up one microsecond of output time
  function automatic int unsigned us_divider(int unsigned clk_hz);
    return (clk_hz >= 32'd1_000_000) ? clk_hz / 32'd1_000_000 : 32'd1;
  endfunction

  // a period opens high unless its high interval is empty
  function automatic phase_e entry_phase(dur_t on_t);
    return (on_t != '0) ? PH_ON : PH_OFF;
  endfunction

  // length of the low interval; an all-zero setting still spans one count
  function automatic dur_t low_len(dur_t on_t, dur_t off_t);
    return (on_t == '0 && off_t == '0) ? dur_t'(1) : off_t;
  endfunction

  // true in the final count of an interval of length len
  function automatic logic final_count(dur_t elapsed, dur_t len);
    return elapsed == (len - dur_t'(1));
  endfunction
endpackage

// File: rtl/pwm_us_tick.sv
module pwm_us_tick #(
  parameter int unsigned DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               div_cnt <= '0;
    else if (hold)            div_cnt <= '0;
    else if (div_cnt == LAST) div_cnt <= '0;
    else                      div_cnt <= div_cnt + CW'(1);
  end

  assign tick = !hold && (div_cnt == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
  import pwm_onoff_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_set,
  input  logic run_clr,
  input  logic one_shot,
  input  dur_t on_cfg,
  input  dur_t off_cfg,
  output logic run_q,
  output logic pwm
);
  logic   run_r;
  phase_e phase_r;
  dur_t   elapsed_r, on_r, off_r;

  dur_t cur_len;
  logic start_evt, phase_end, period_end;

  assign cur_len    = (phase_r == PH_ON) ? on_r : low_len(on_r, off_r);
  assign start_evt  = run_set && !run_r && !run_clr;
  assign phase_end  = run_r && tick && final_count(elapsed_r, cur_len);
  assign period_end = phase_end && ((phase_r == PH_OFF) || (off_r == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_r     <= 1'b0;
      phase_r   <= PH_OFF;
      elapsed_r <= '0;
      on_r      <= '0;
      off_r     <= '0;
    end else if (run_clr) begin
      run_r     <= 1'b0;
      phase_r   <= PH_OFF;
      elapsed_r <= '0;
    end else if (start_evt) begin
      run_r     <= 1'b1;
      on_r      <= on_cfg;
      off_r     <= off_cfg;
      phase_r   <= entry_phase(on_cfg);
      elapsed_r <= '0;
    end else if (period_end) begin
      elapsed_r <= '0;
      if (one_shot) begin
        run_r   <= 1'b0;
        phase_r <= PH_OFF;
      end else begin
        on_r    <= on_cfg;
        off_r   <= off_cfg;
        phase_r <= entry_phase(on_cfg);
      end
    end else if (phase_end) begin
      phase_r   <= PH_OFF;
      elapsed_r <= '0;
    end else if (run_r && tick) begin
      elapsed_r <= elapsed_r + dur_t'(1);
    end
  end

  assign run_q = run_r;
  assign pwm   = run_r && (phase_r == PH_ON);

  // R7
  clr_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr |=> (!pwm && !run_r));
  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && one_shot && !run_clr) |=> !run_r);
  // R9
  zero_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && on_r == '0) |-> !pwm);
  // R10
  zero_off_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && on_r != '0 && off_r == '0) |-> pwm);
  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && !period_end && !run_clr) |=> ($stable(on_r) && $stable(off_r)));
  // R2
  phase_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && !tick && !run_clr) |=> $stable(phase_r));
  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && run_set && !run_clr && !tick) |=> $stable(elapsed_r));
endmodule

// File: rtl/pwm_onoff_gen.sv
module pwm_onoff_gen
  import pwm_onoff_pkg::*;
#(
  parameter int unsigned CLK_HZ = 250_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] on_lo,
  input  logic [BYTE_W-1:0] on_hi,
  input  logic [BYTE_W-1:0] off_lo,
  input  logic [BYTE_W-1:0] off_hi,
  input  logic              one_shot,
  input  logic              run_set,
  input  logic              run_clr,
  output logic              run_q,
  output logic              pwm_out
);
  localparam int unsigned DIV = us_divider(CLK_HZ);

  dur_t on_cfg, off_cfg;
  logic us_tick, run_w;

  assign on_cfg  = {on_hi, on_lo};
  assign off_cfg = {off_hi, off_lo};

  pwm_us_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (!run_w),
    .tick  (us_tick)
  );

  pwm_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .run_set  (run_set),
    .run_clr  (run_clr),
    .one_shot (one_shot),
    .on_cfg   (on_cfg),
    .off_cfg  (off_cfg),
    .run_q    (run_w),
    .pwm      (pwm_out)
  );

  assign run_q = run_w;

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |-> !pwm_out);
endmodule

// File: tb/pwm_onoff_gen_bench.sv
module pwm_onoff_gen_bench;
  localparam int unsigned HZ = 25_000_000;
  localparam int US = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] on_lo = '0, on_hi = '0, off_lo = '0, off_hi = '0;
  logic one_shot = 1'b0, run_set = 1'b0, run_clr = 1'b0;
  logic run_q, pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwm_onoff_gen #(.CLK_HZ(HZ)) u_pwm_onoff_gen (
    .clk(clk), .rst_n(rst_n), .on_lo(on_lo), .on_hi(on_hi),
    .off_lo(off_lo), .off_hi(off_hi), .one_shot(one_shot),
    .run_set(run_set), .run_clr(run_clr), .run_q(run_q), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int on_t, input int off_t, input bit os);
    on_lo = on_t[7:0]; on_hi = on_t[15:8];
    off_lo = off_t[7:0]; off_hi = off_t[15:8];
    one_shot = os;
  endtask

  task automatic start();
    run_set = 1'b1;
    @(negedge clk);
    run_set = 1'b0;
  endtask

  task automatic stop();
    run_clr = 1'b1;
    @(negedge clk);
    run_clr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pwm_run(input logic v, input int limit, output int len);
    len = 0;
    while (pwm_out === v && len < limit) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic runq_run(input int limit, output int len);
    len = 0;
    while (run_q === 1'b1 && len < limit) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(pwm_out === 1'b0, "R1 pwm", int'(pwm_out), 0);
    chk(run_q === 1'b0, "R1 run", int'(run_q), 0);
  endtask

  task automatic t_basic();
    int len;
    set_cfg(3, 2, 1'b0); start();
    pwm_run(1'b1, 1000, len); chk(len == 3*US, "R2 high", len, 3*US);
    pwm_run(1'b0, 1000, len); chk(len == 2*US, "R2 low", len, 2*US);
    pwm_run(1'b1, 1000, len); chk(len == 3*US, "R4 repeat high", len, 3*US);
    run_clr = 1'b1; @(negedge clk); run_clr = 1'b0;
    chk(pwm_out === 1'b0 && run_q === 1'b0, "R7 clear", int'(run_q), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_square();
    int len;
    set_cfg(1, 1, 1'b0); start();
    pwm_run(1'b1, 100, len); chk(len == US, "R3 high", len, US);
    pwm_run(1'b0, 100, len); chk(len == US, "R3 low", len, US);
    pwm_run(1'b1, 100, len); chk(len == US, "R3 next high", len, US);
    stop();
  endtask

  task automatic t_hibyte_oneshot();
    int len;
    set_cfg(16'h0100, 16'h0001, 1'b1); start();
    pwm_run(1'b1, 10000, len); chk(len == 256*US, "R2 high byte", len, 256*US);
    runq_run(1000, len); chk(len == US, "R5 low then stop", len, US);
    chk(pwm_out === 1'b0 && run_q === 1'b0, "R5 stopped", int'(run_q), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ignore_set();
    int len;
    set_cfg(4, 4, 1'b0); start();
    repeat (10) @(negedge clk);
    run_set = 1'b1; @(negedge clk); run_set = 1'b0;
    pwm_run(1'b1, 1000, len); chk(len == 4*US - 11, "R6 no restart", len, 4*US - 11);
    stop();
  endtask

  task automatic t_clr_priority();
    int len;
    set_cfg(2, 2, 1'b0); start();
    pwm_run(1'b1, 1000, len);
    run_set = 1'b1; run_clr = 1'b1; @(negedge clk);
    run_set = 1'b0; run_clr = 1'b0;
    chk(run_q === 1'b0 && pwm_out === 1'b0, "R7 clr wins", int'(run_q), 0);
    repeat (5) @(negedge clk);
    start();
    pwm_run(1'b1, 1000, len); chk(len == 2*US, "R7 fresh start", len, 2*US);
    stop();
  endtask

  task automatic t_update();
    int len;
    set_cfg(2, 2, 1'b0); start();
    set_cfg(5, 1, 1'b0);
    pwm_run(1'b1, 1000, len); chk(len == 2*US, "R8 old high", len, 2*US);
    pwm_run(1'b0, 1000, len); chk(len == 2*US, "R8 old low", len, 2*US);
    pwm_run(1'b1, 1000, len); chk(len == 5*US, "R8 new high", len, 5*US);
    pwm_run(1'b0, 1000, len); chk(len == US, "R8 new low", len, US);
    stop();
  endtask

  task automatic t_zero_on();
    int len;
    set_cfg(0, 3, 1'b0); start();
    pwm_run(1'b0, 200, len); chk(len == 200, "R9 stays low", len, 200);
    chk(run_q === 1'b1, "R9 still running", int'(run_q), 1);
    stop();
    set_cfg(0, 0, 1'b1); start();
    runq_run(1000, len); chk(len == US, "R9 empty period", len, US);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_zero_off();
    int len;
    set_cfg(2, 0, 1'b0); start();
    pwm_run(1'b1, 300, len); chk(len == 300, "R10 stays high", len, 300);
    one_shot = 1'b1;
    pwm_run(1'b1, 1000, len); chk(len == 2*US, "R5 last period", len, 2*US);
    chk(run_q === 1'b0, "R5 run cleared", int'(run_q), 0);
    one_shot = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_square();
    t_hibyte_oneshot();
    t_ignore_set();
    t_clr_priority();
    t_update();
    t_zero_on();
    t_zero_off();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule